// File: doc/BRIEF.md
# Overlapping 110 Serial Pattern Detector

This block watches a serial bit stream, one bit per clock, and flags every place where the three most recent bits read 1, 1, 0 in arrival order. Windows overlap: each new bit opens a fresh three-bit window. Disjoint groups of three are never used. The history is a three-bit shift register. The newest bit enters at the least significant position, and older bits move toward the most significant end.

Two match outputs come from that one history register. The state-only output looks at the stored bits alone and rises in the cycle after the final 0 has been clocked in. The state-plus-input output combines the two newest stored bits with the bit now on the input. It therefore rises one cycle earlier, while the final 0 is still being presented.

A synchronous reset empties the history. The state-plus-input output is held low while reset is asserted.

Top module: `ser110Detect`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the history to all zeros. `matchMoore` is 0 in the cycle after reset and stays 0 until at least three bits have been shifted in.
- R2: At each rising edge with rst low, the bit on `serialIn` enters history bit 0, and the older bits shift toward bit 2. From history 010, an input of 0 gives 100 and an input of 1 gives 101; neither is a match.
- R3: `matchMoore` is 1 exactly when the history holds 110. That is, the oldest of the last three clocked bits was 1, the middle was 1 and the newest was 0.
- R4: `matchMealy` is 1 exactly when rst is low, the two newest stored bits are both 1, and `serialIn` is 0 in the same cycle. It follows `serialIn` combinationally.
- R5: Whenever at least one bit has been clocked in since reset, `matchMoore` equals the value `matchMealy` had one clock earlier.
- R6: Matches overlap across bit boundaries. Neither output is high in two consecutive cycles, and the stream 1101101100 gives three matches, one after each of its three zeros that follow a 1,1 pair.
- R7: `matchMealy` is 0 in every cycle where rst is high, whatever the history and `serialIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| serialIn | input | 1 | Serial data, one bit per clock |
| matchMoore | output | 1 | High when the stored history is 110 |
| matchMealy | output | 1 | High when the stored bits end in 11 and the present input is 0 |

## Verification
The assertions assume that reset is asserted from time zero until the first clock edge, and that `serialIn` is settled before each rising edge. The R5 relation also depends on reset being released only at a clock edge. The bench meets these conditions by holding reset from the start and by driving every input, including reset, on the falling edge. It sweeps all 1024 ten-bit streams from a fresh reset and a long unbroken random stream, so every history value is reached and so is every transition into and out of it. It also asserts reset while the history ends in 11 and the input is 0, which is the one case where the R7 gating changes `matchMealy`.

// File: rtl/ser110Pkg.sv
package ser110Pkg;
  localparam int HIST_W = 3;
  localparam logic [HIST_W-1:0] PAT_BITS = 3'b110;
  localparam int LEAD_W = HIST_W - 1;
  localparam logic [LEAD_W-1:0] PAT_LEAD = PAT_BITS[HIST_W-1:1];
  localparam logic PAT_LAST = PAT_BITS[0];

  typedef struct packed {
    logic clear;
    logic load;
  } histCtl_t;
endpackage

// File: rtl/ser110Hist.sv
module ser110Hist
  import ser110Pkg::*;
(
  input  logic              clk,
  input  histCtl_t          ctl,
  input  logic              serialIn,
  output logic [HIST_W-1:0] histQ
);
  logic [HIST_W-1:0] histNext;

  assign histNext = {histQ[HIST_W-2:0], serialIn};

  for (genvar k = 0; k < HIST_W; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (ctl.clear) begin
        histQ[k] <= 1'b0;
      end else if (ctl.load) begin
        histQ[k] <= histNext[k];
      end
    end
  end
endmodule

// File: rtl/ser110Ctrl.sv
module ser110Ctrl
  import ser110Pkg::*;
(
  input  logic              rst,
  input  logic              serialIn,
  input  logic [HIST_W-1:0] histQ,
  output histCtl_t          ctl,
  output logic              matchMoore,
  output logic              matchMealy
);
  logic leadHit;

  always_comb begin
    ctl.clear = rst;
    ctl.load  = !rst;
  end

  assign leadHit    = (histQ[LEAD_W-1:0] == PAT_LEAD);
  assign matchMoore = (histQ == PAT_BITS);
  assign matchMealy = !rst && leadHit && (serialIn == PAT_LAST);
endmodule

// File: rtl/ser110Detect.sv
module ser110Detect
  import ser110Pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic serialIn,
  output logic matchMoore,
  output logic matchMealy
);
  histCtl_t          histCtl;
  logic [HIST_W-1:0] histQ;

  ser110Hist hist_i (
    .clk      (clk),
    .ctl      (histCtl),
    .serialIn (serialIn),
    .histQ    (histQ)
  );

  ser110Ctrl ctrl_i (
    .rst        (rst),
    .serialIn   (serialIn),
    .histQ      (histQ),
    .ctl        (histCtl),
    .matchMoore (matchMoore),
    .matchMealy (matchMealy)
  );
endmodule

// File: rtl/ser110Chk.sv
module ser110Chk (
  input logic clk,
  input logic rst,
  input logic serialIn,
  input logic matchMoore,
  input logic matchMealy
);
  logic [1:0] bitCnt;
  logic       prevMealy;
  logic       prevIn;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt    <= 2'd0;
      prevMealy <= 1'b0;
      prevIn    <= 1'b0;
    end else begin
      if (bitCnt != 2'd3) bitCnt <= bitCnt + 2'd1;
      prevMealy <= matchMealy;
      prevIn    <= serialIn;
    end
  end

  AST_MOORE_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (rst)
    (bitCnt != 2'd3) |-> !matchMoore); // R1
  AST_MOORE_NEWEST_ZERO: assert property (@(posedge clk) disable iff (rst)
    (matchMoore && bitCnt != 2'd0) |-> !prevIn); // R3
  AST_MEALY_NEEDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    matchMealy |-> !serialIn); // R4
  AST_MOORE_FOLLOWS_MEALY: assert property (@(posedge clk) disable iff (rst)
    (bitCnt != 2'd0) |-> (matchMoore == prevMealy)); // R5
  AST_MOORE_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
    matchMoore |=> !matchMoore); // R6
  AST_MEALY_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
    matchMealy |=> !matchMealy); // R6
  AST_MEALY_QUIET_IN_RESET: assert property (@(posedge clk)
    rst |-> !matchMealy); // R7
endmodule

bind ser110Detect ser110Chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .serialIn   (serialIn),
  .matchMoore (matchMoore),
  .matchMealy (matchMealy)
);

// File: tb/ser110Detect_tb_top.sv
module ser110Detect_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serialIn = 1'b0;
  logic matchMoore;
  logic matchMealy;

  int checks = 0;
  int fails = 0;
  int nBits = 0;
  logic w2 = 1'b0, w1 = 1'b0, w0 = 1'b0;
  logic lastExpMealy = 1'b0;
  int mealyHits;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ser110Detect dut_i (
    .clk(clk), .rst(rst), .serialIn(serialIn),
    .matchMoore(matchMoore), .matchMealy(matchMealy)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (bits since reset %0d)", req, act, exp, nBits);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    serialIn = 1'b0;
    #1 check("R7", matchMealy, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check("R1", matchMoore, 1'b0);
    rst = 1'b0;
    nBits = 0;
    w2 = 1'b0; w1 = 1'b0; w0 = 1'b0;
    lastExpMealy = 1'b0;
  endtask

  task automatic stepBit(input logic b);
    logic expMoore, expMealy;
    @(negedge clk);
    expMoore = (nBits >= 3) && w2 && w1 && !w0;
    check("R3", matchMoore, expMoore);
    if (nBits >= 1) check("R5", matchMoore, lastExpMealy);
    serialIn = b;
    expMealy = (nBits >= 2) && w1 && w0 && !b;
    #1 check("R4", matchMealy, expMealy);
    if (matchMealy) mealyHits++;
    lastExpMealy = expMealy;
    @(posedge clk);
    w2 = w1; w1 = w0; w0 = b;
    nBits++;
  endtask

  initial begin
    logic [9:0] directed;
    directed = 10'b1101101100;

    // R1: outputs are quiet straight out of reset
    @(negedge clk);
    check("R1", matchMoore, 1'b0);
    check("R7", matchMealy, 1'b0);
    doReset();

    // R6: directed overlapping stream, oldest bit first
    mealyHits = 0;
    for (int i = 9; i >= 0; i--) stepBit(directed[i]);
    stepBit(1'b1);
    check("R6", logic'(mealyHits == 3), 1'b1);

    // R2: from 010, input 0 -> 100 and input 1 -> 101, neither matching
    doReset();
    stepBit(1'b0); stepBit(1'b1); stepBit(1'b0); stepBit(1'b0);
    stepBit(1'b1);
    doReset();
    stepBit(1'b0); stepBit(1'b1); stepBit(1'b0); stepBit(1'b1);
    stepBit(1'b1);
    stepBit(1'b0);
    @(negedge clk);
    check("R2", matchMoore, 1'b1);

    // R7: reset asserted while history ends 11 and the input is 0
    doReset();
    stepBit(1'b1); stepBit(1'b1);
    doReset();
    stepBit(1'b0);

    // R1..R5: every 10-bit stream from a fresh reset
    for (int s = 0; s < 1024; s++) begin
      doReset();
      for (int i = 9; i >= 0; i--) stepBit(s[i]);
    end

    // R3..R6: long unbroken random stream
    doReset();
    for (int i = 0; i < 3000; i++) stepBit(1'($urandom_range(1, 0)));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule